// File: doc/BRIEF.md
# Coherent Phase Readout Register

This block exposes a 16-bit signed phase measurement through a byte-wide register bus. Two phase words arrive in parallel, one from each of two phase-locked loops, already averaged upstream; a select input decides which loop is reported. The values are two's-complement integers in which one unit stands for roughly 0.707 degrees of phase difference. The block passes them through without scaling or conversion.

Because the bus carries one byte per access, a live 16-bit word could change between the two reads. To prevent that, a read of the low-byte address copies the whole selected word into a holding register in the same clock edge that returns its low byte. A following read of the high-byte address returns the upper byte of that copy and takes no new sample. Software therefore reads the low byte first and the high byte right after it, and always gets two halves of one sample.

The reset input is asynchronous and active low. Its release is synchronized to the clock inside the block, so the block leaves reset two clock edges after the input rises.

Top module: `phase_readout`

## Requirements
- R1: While reset is asserted, and after it, until the first read, the read data is 0x00 and the holding register is 0x0000. A high-byte read with no earlier low-byte read returns 0x00.
- R2: A read strobe at address 0x77 (low byte) puts bits [7:0] of the currently selected phase on the read data after the next rising clock edge.
- R3: The same low-byte read stores all 16 bits of the selected phase in the holding register. A later read strobe at address 0x78 (high byte) returns bits [15:8] of that stored word, even if the live input has changed since.
- R4: With the select input at 0 the primary loop's phase is sampled; with it at 1 the secondary loop's phase is sampled.
- R5: A change of the select input after a low-byte read has no effect on the high byte returned by the next high-byte read.
- R6: A high-byte read never loads the holding register, so repeated high-byte reads return the same byte.
- R7: A read strobe at any address other than 0x77 or 0x78 returns 0x00 and leaves the holding register unchanged.
- R8: In a cycle with no read strobe, the read data keeps its previous value and the holding register is not loaded, whatever the address.
- R9: The value is carried as two's complement without change; a negative phase (bit 15 set) reads back with its sign bit intact in the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| primary_phase_i | input | 16 | Averaged signed phase of the primary loop |
| secondary_phase_i | input | 16 | Averaged signed phase of the secondary loop |
| sel_secondary_i | input | 1 | 0 reports the primary loop, 1 the secondary loop |
| bus_addr_i | input | 8 | Register address of the access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_rdata_o | output | 8 | Registered read data |

## Verification
Every read result appears on the read data one rising edge after the cycle in which the strobe and address are presented. The holding register is loaded at that same edge, so a high-byte read in the very next cycle already sees the new capture. The bench drives each stimulus vector just after a falling edge and samples the read data at the following falling edge, which is exactly one rising edge later. The asynchronous reset clear is checked a moment after the reset input falls, and the synchronized release is given several cycles before the first access.

// File: rtl/phase_readout_pkg.sv
package phase_readout_pkg;

  // Kind of bus access seen in the current cycle.
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_LOW   = 2'd1,
    ACC_HIGH  = 2'd2,
    ACC_OTHER = 2'd3
  } acc_e;

endpackage

// File: rtl/pr_rst_sync.sv
module pr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_nxt;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pr_loop_mux.sv
module pr_loop_mux #(
  parameter int unsigned PHASE_W = 16
) (
  input  logic [PHASE_W-1:0] primary_i,
  input  logic [PHASE_W-1:0] secondary_i,
  input  logic               sel_secondary_i,
  output logic [PHASE_W-1:0] phase_o
);

  always_comb begin
    if (sel_secondary_i) begin
      phase_o = secondary_i;
    end else begin
      phase_o = primary_i;
    end
  end

endmodule

// File: rtl/pr_snapshot.sv
module pr_snapshot #(
  parameter int unsigned PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_en_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic [PHASE_W-1:0] hold_o
);

  logic [PHASE_W-1:0] hold_q;
  logic [PHASE_W-1:0] hold_nxt;

  always_comb begin
    hold_nxt = phase_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (cap_en_i) begin
      hold_q <= hold_nxt;
    end
  end

  assign hold_o = hold_q;

endmodule

// File: rtl/pr_rd_port.sv
module pr_rd_port
  import phase_readout_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h77,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h78
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] live_lo_i,
  input  logic [DATA_W-1:0] held_hi_i,
  output acc_e              acc_o,
  output logic [DATA_W-1:0] rdata_o
);

  acc_e              acc;
  logic              rd_ld;
  logic [DATA_W-1:0] rdata_nxt;
  logic [DATA_W-1:0] rdata_q;

  // Address decode of the current access.
  always_comb begin
    acc = ACC_NONE;
    if (rd_i) begin
      if (addr_i == LO_ADDR) begin
        acc = ACC_LOW;
      end else if (addr_i == HI_ADDR) begin
        acc = ACC_HIGH;
      end else begin
        acc = ACC_OTHER;
      end
    end
  end

  // Next read data and its load enable.
  always_comb begin
    rd_ld = (acc != ACC_NONE);
    case (acc)
      ACC_LOW:  rdata_nxt = live_lo_i;
      ACC_HIGH: rdata_nxt = held_hi_i;
      default:  rdata_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_ld) begin
      rdata_q <= rdata_nxt;
    end
  end

  assign acc_o   = acc;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/phase_readout.sv
module phase_readout
  import phase_readout_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h77,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h78,
  localparam int unsigned PHASE_W = 2 * DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] primary_phase_i,
  input  logic [PHASE_W-1:0] secondary_phase_i,
  input  logic               sel_secondary_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_rd_i,
  output logic [DATA_W-1:0]  bus_rdata_o
);

  logic               rst_int_n;
  logic [PHASE_W-1:0] phase_sel;
  logic [PHASE_W-1:0] hold;
  acc_e               acc;
  logic               cap_en;

  pr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pr_loop_mux #(.PHASE_W(PHASE_W)) u_loop_mux (
    .primary_i       (primary_phase_i),
    .secondary_i     (secondary_phase_i),
    .sel_secondary_i (sel_secondary_i),
    .phase_o         (phase_sel)
  );

  assign cap_en = (acc == ACC_LOW);

  pr_snapshot #(.PHASE_W(PHASE_W)) u_snapshot (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cap_en_i (cap_en),
    .phase_i  (phase_sel),
    .hold_o   (hold)
  );

  pr_rd_port #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .LO_ADDR (LO_ADDR),
    .HI_ADDR (HI_ADDR)
  ) u_rd_port (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rd_i      (bus_rd_i),
    .addr_i    (bus_addr_i),
    .live_lo_i (phase_sel[DATA_W-1:0]),
    .held_hi_i (hold[PHASE_W-1:DATA_W]),
    .acc_o     (acc),
    .rdata_o   (bus_rdata_o)
  );

  // R2: a low-byte read returns the live selected low byte one edge later.
  p_low_read_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_rd_i && bus_addr_i == LO_ADDR)
      |=> bus_rdata_o == $past(sel_secondary_i ? secondary_phase_i[DATA_W-1:0]
                                               : primary_phase_i[DATA_W-1:0]));

  // R3, R4: the low-byte read stores the full word of the selected loop.
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_rd_i && bus_addr_i == LO_ADDR)
      |=> hold == $past(sel_secondary_i ? secondary_phase_i : primary_phase_i));

  // R3: a high-byte read returns the upper half of the stored word.
  p_high_read_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_rd_i && bus_addr_i == HI_ADDR)
      |=> bus_rdata_o == $past(hold[PHASE_W-1:DATA_W]));

  // R6, R7, R8: only a low-byte read strobe may change the stored word.
  p_hold_keep_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(bus_rd_i && bus_addr_i == LO_ADDR) |=> $stable(hold));

  // R7: reads of unmapped addresses return zero.
  p_other_zero_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_rd_i && bus_addr_i != LO_ADDR && bus_addr_i != HI_ADDR)
      |=> bus_rdata_o == '0);

  // R8: without a strobe the read data keeps its value.
  p_idle_keep_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_rd_i |=> $stable(bus_rdata_o));

endmodule

// File: tb/phase_readout_bench.sv
module phase_readout_bench;

  localparam int CLK_P = 10;
  localparam int NV    = 14;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] prim;
  logic [15:0] sec;
  logic        sel;
  logic [7:0]  addr;
  logic        rd;
  logic [7:0]  rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  phase_readout u_phase_readout (
    .clk               (clk),
    .rst_n             (rst_n),
    .primary_phase_i   (prim),
    .secondary_phase_i (sec),
    .sel_secondary_i   (sel),
    .bus_addr_i        (addr),
    .bus_rd_i          (rd),
    .bus_rdata_o       (rdata)
  );

  // Vector: {sel, primary, secondary, addr, rd, expected read data}
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 16'h8000, 16'h1234, 8'h78, 1'b1, 8'h00}, // high before any low
    {1'b0, 16'hA5C3, 16'h1234, 8'h77, 1'b1, 8'hC3}, // low read, primary
    {1'b0, 16'h0F0F, 16'h1234, 8'h78, 1'b1, 8'hA5}, // high of capture
    {1'b0, 16'h0F0F, 16'h1234, 8'h78, 1'b1, 8'hA5}, // repeat high
    {1'b1, 16'h0F0F, 16'hFE01, 8'h77, 1'b1, 8'h01}, // low read, secondary
    {1'b0, 16'h7F80, 16'h0000, 8'h78, 1'b1, 8'hFE}, // select flipped
    {1'b0, 16'h7F80, 16'h0000, 8'h10, 1'b1, 8'h00}, // unmapped
    {1'b0, 16'h7F80, 16'h0000, 8'h78, 1'b1, 8'hFE}, // hold untouched
    {1'b0, 16'h7F80, 16'h0000, 8'h77, 1'b0, 8'hFE}, // no strobe
    {1'b0, 16'h7F80, 16'h0000, 8'h78, 1'b1, 8'hFE}, // no capture taken
    {1'b0, 16'h7F80, 16'h0000, 8'h77, 1'b1, 8'h80}, // low read
    {1'b0, 16'h1111, 16'h0000, 8'h78, 1'b1, 8'h7F}, // high
    {1'b1, 16'h1111, 16'h8001, 8'h77, 1'b1, 8'h01}, // negative value
    {1'b0, 16'h0000, 16'h0000, 8'h78, 1'b1, 8'h80}  // sign bit kept
  };

  string vreq [NV] = '{"R1", "R2", "R3", "R6", "R4", "R5", "R7",
                       "R7", "R8", "R8", "R2", "R3", "R4", "R9"};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: read data %h, expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic drive_idle();
    sel  = 1'b0;
    prim = 16'h0000;
    sec  = 16'h0000;
    addr = 8'h00;
    rd   = 1'b0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive_idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", rdata, 8'h00);          // R1: reset value during reset
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // Table walk: drive after a falling edge, sample at the next one.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i != 0) chk(vreq[i-1], rdata, VEC[i-1][7:0]);
      {sel, prim, sec, addr, rd} = VEC[i][49:8];
    end
    @(negedge clk);
    chk(vreq[NV-1], rdata, VEC[NV-1][7:0]);
    drive_idle();

    // R1: asynchronous clear in the middle of a run.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", rdata, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: stored word cleared by reset, high read returns zero.
    @(negedge clk);
    prim = 16'hBEEF;
    addr = 8'h78;
    rd   = 1'b1;
    @(negedge clk);
    chk("R1", rdata, 8'h00);
    drive_idle();

    // R2, R3: back-to-back low then high after reset.
    prim = 16'hBEEF;
    addr = 8'h77;
    rd   = 1'b1;
    @(negedge clk);
    chk("R2", rdata, 8'hEF);
    prim = 16'h0000;
    addr = 8'h78;
    @(negedge clk);
    chk("R3", rdata, 8'hBE);
    drive_idle();

    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule